// File: doc/BRIEF.md
# Periodic Tick Generator

This block turns a 32768 Hz timebase into a programmable periodic tick for a real-time clock. The timebase arrives as a one-cycle enable pulse on the system clock. Each pulse advances a free-running 15-bit cycle counter. A 4-bit rate code selects a power-of-two period, counted in timebase pulses. When the counter reaches the next multiple of that period, the block emits a tick.

Each tick produces three one-cycle outputs: a tick strobe, a request to set the periodic flag, and, only while the periodic-interrupt enable is high, a request to set the interrupt flag. A 3-bit divider-control field gates the counter:

- Low values let the counter run.
- Other values freeze it.
- A value with its two upper bits both set holds the divider in reset and clears the counter.

Top module: `periodic_tick_gen`

## Requirements
- R1: While reset is asserted and after it is released with no timebase pulses, `tick`, `pf_set` and `irq_set` are all 0.
- R2: A rate code of 0 produces no tick, whatever the counter does.
- R3: For a rate code n from 3 to 15, the period is 2^(n-1) timebase pulses (code 3 gives 4, code 15 gives 16384).
- R4: Rate code 1 gives a period of 128 pulses and rate code 2 gives 256 pulses.
- R5: A tick happens exactly on timebase pulses that bring the 15-bit counter to a multiple of the period, including the wrap from 32767 to 0.
- R6: A tick raises `tick` and `pf_set` for one clock, on the clock after the edge that carried the timebase pulse. `irq_set` rises with them only if `pie` was 1 at that edge.
- R7: The counter advances only while `div_ctl` is 0, 1 or 2. Other values that are not a divider reset freeze the count, and alignment resumes from the frozen value.
- R8: When `div_ctl[2:1]` is 2'b11, the counter is cleared and no tick occurs. After release, the first tick comes after exactly one full period of pulses.
- R9: In a cycle where `rate_code` differs from its previous-cycle value, no tick is issued. Alignment to the new period continues from the current count.
- R10: With the timebase enable held high on every clock, `tick` is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tb_en | input | 1 | One-cycle enable for each 32768 Hz timebase period |
| rate_code | input | 4 | Period select; 0 disables ticks |
| div_ctl | input | 3 | Divider control: 0..2 run; bits 2:1 = 11 clear and hold; any other value freezes |
| pie | input | 1 | Periodic-interrupt enable |
| tick | output | 1 | One-cycle periodic tick strobe |
| pf_set | output | 1 | Request to set the periodic flag |
| irq_set | output | 1 | Request to set the interrupt flag and raise the line |

## Verification
The bound checker covers the following on every cycle:
- a tick lands only on a counter multiple of the active period;
- it follows a timebase pulse, a nonzero code and a running divider;
- it lasts one clock;
- `irq_set` needs a prior `pie`;
- a divider reset clears the counter.

Only the bench scenarios can show the rest: that the measured spacing equals the period chosen by each code, including the remapped codes 1 and 2 and the counter wrap at code 15; that a code change swallows the boundary it lands on; and that a frozen or reset divider resumes with the right alignment.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam int DIV_W = 3;

  typedef enum logic [1:0] {
    DIV_RUN   = 2'd0,
    DIV_HOLD  = 2'd1,
    DIV_CLEAR = 2'd2
  } div_mode_e;
endpackage

// File: rtl/ptg_rst_sync.sv
module ptg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ptg_div_decode.sv
module ptg_div_decode
  import ptg_pkg::*;
(
  input  logic [DIV_W-1:0] div_ctl,
  output div_mode_e        mode
);
  always_comb begin
    if (div_ctl[2:1] == 2'b11)       mode = DIV_CLEAR;
    else if (div_ctl <= DIV_W'(2))   mode = DIV_RUN;
    else                             mode = DIV_HOLD;
  end
endmodule

// File: rtl/ptg_rate_decode.sv
module ptg_rate_decode #(
  parameter int CNT_W  = 15,
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code,
  output logic              active,
  output logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  mask
);
  localparam logic [CODE_W-1:0] REMAP_C1 = CODE_W'(7);
  localparam logic [CODE_W-1:0] REMAP_C2 = CODE_W'(8);

  logic [CODE_W-1:0] expo;

  always_comb begin
    active = (code != '0);
    if (code == CODE_W'(1))      expo = REMAP_C1;
    else if (code == CODE_W'(2)) expo = REMAP_C2;
    else if (active)             expo = code - CODE_W'(1);
    else                         expo = '0;
    period = active ? (CNT_W'(1) << expo) : '0;
    mask   = period - CNT_W'(1);
  end
endmodule

// File: rtl/ptg_counter.sv
module ptg_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);
  logic cnt_en;

  always_comb begin
    cnt_en  = clear | step;
    cnt_nxt = cnt_q;
    if (clear)     cnt_nxt = '0;
    else if (step) cnt_nxt = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/ptg_align.sv
module ptg_align #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clear,
  input  logic             code_chg,
  input  logic             active,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] mask,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             pie,
  output logic             tick,
  output logic             pf_set,
  output logic             irq_set
);
  logic [CNT_W-1:0] target_q, target_nxt;
  logic             target_en;
  logic             hit;
  logic             tick_q, pf_q, irq_q;

  always_comb begin
    hit        = step & active & ~code_chg & (cnt_nxt == target_q);
    target_en  = code_chg | clear | hit;
    target_nxt = target_q;
    if (code_chg || clear) target_nxt = (cnt_nxt & ~mask) + period;
    else if (hit)          target_nxt = target_q + period;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         target_q <= '0;
    else if (target_en) target_q <= target_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      pf_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      tick_q <= hit;
      pf_q   <= hit;
      irq_q  <= hit & pie;
    end
  end

  assign tick    = tick_q;
  assign pf_set  = pf_q;
  assign irq_set = irq_q;
endmodule

// File: rtl/periodic_tick_gen.sv
module periodic_tick_gen
  import ptg_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_en,
  input  logic [CODE_W-1:0] rate_code,
  input  logic [DIV_W-1:0]  div_ctl,
  input  logic              pie,
  output logic              tick,
  output logic              pf_set,
  output logic              irq_set
);
  logic              rst_sync_n;
  div_mode_e         mode;
  logic              active;
  logic [CNT_W-1:0]  period, mask;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [CODE_W-1:0] code_q;
  logic              code_chg, step, clear;

  ptg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ptg_div_decode u_div (.div_ctl(div_ctl), .mode(mode));

  ptg_rate_decode #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_rate (
    .code(rate_code), .active(active), .period(period), .mask(mask)
  );

  always_comb begin
    code_chg = (rate_code != code_q);
    step     = tb_en & (mode == DIV_RUN);
    clear    = (mode == DIV_CLEAR);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   code_q <= '0;
    else if (code_chg) code_q <= rate_code;
  end

  ptg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .step(step), .clear(clear),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  ptg_align #(.CNT_W(CNT_W)) u_align (
    .clk(clk), .rst_n(rst_sync_n), .step(step), .clear(clear),
    .code_chg(code_chg), .active(active), .period(period), .mask(mask),
    .cnt_nxt(cnt_nxt), .pie(pie),
    .tick(tick), .pf_set(pf_set), .irq_set(irq_set)
  );
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker #(
  parameter int CNT_W  = 15,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tb_en,
  input logic [CODE_W-1:0] rate_code,
  input logic [2:0]        div_ctl,
  input logic              pie,
  input logic              tick,
  input logic              pf_set,
  input logic              irq_set,
  input logic [CNT_W-1:0]  cnt_q
);
  function automatic logic [CNT_W-1:0] low_mask(input logic [CODE_W-1:0] c);
    int e;
    if (c == CODE_W'(1))      e = 7;
    else if (c == CODE_W'(2)) e = 8;
    else                      e = int'(c) - 1;
    if (e < 0) e = 0;
    return (CNT_W'(1) << e) - CNT_W'(1);
  endfunction

  p_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ((cnt_q & low_mask($past(rate_code))) == '0));

  p_no_tick_code0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ($past(rate_code) != '0));

  p_tick_after_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pf_set |-> $past(tb_en));

  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> (tick && $past(pie)));

  p_run_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ($past(div_ctl) <= 3'd2));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ctl[2:1] == 2'b11) |=> (cnt_q == '0));

  p_single_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

bind periodic_tick_gen ptg_checker #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tb_en(tb_en), .rate_code(rate_code),
  .div_ctl(div_ctl), .pie(pie), .tick(tick), .pf_set(pf_set),
  .irq_set(irq_set), .cnt_q(cnt_q)
);

// File: tb/periodic_tick_gen_bench.sv
`timescale 1ns/1ps
module periodic_tick_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tb_en;
  logic [3:0] rate_code;
  logic [2:0] div_ctl;
  logic       pie;
  logic       tick, pf_set, irq_set;

  int n_checks = 0;
  int n_fail   = 0;
  int mcnt     = 0;
  int n_ticks  = 0;
  logic [3:0] prev_code = 4'd0;
  logic [3:0] cur_code  = 4'd0;
  logic [2:0] cur_div   = 3'd0;
  logic       cur_pie   = 1'b0;

  always #2 clk = ~clk;

  periodic_tick_gen u_periodic_tick_gen (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .rate_code(rate_code),
    .div_ctl(div_ctl), .pie(pie), .tick(tick), .pf_set(pf_set),
    .irq_set(irq_set)
  );

  function automatic int per_of(input logic [3:0] c);
    if (c == 4'd1) return 128;
    if (c == 4'd2) return 256;
    return 1 << (int'(c) - 1);
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {tick,pf,irq} actual=%b expected=%b (model count %0d)", req, act, exp, mcnt);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive all inputs from a falling edge, then check at the next falling edge.
  task automatic drive_step(input logic en, input logic [3:0] code,
                            input logic [2:0] div, input logic ie, input string req);
    logic run, chg, e;
    tb_en = en; rate_code = code; div_ctl = div; pie = ie;
    @(negedge clk);
    run = (div <= 3'd2);
    chg = (code != prev_code);
    if (div[2:1] == 2'b11) mcnt = 0;
    else if (run && en)    mcnt = (mcnt + 1) % 32768;
    e = en && run && (code != 4'd0) && !chg && ((mcnt % per_of(code)) == 0);
    if (tick) n_ticks++;
    check(req, {tick, pf_set, irq_set}, {e, e, e && ie});
    prev_code = code;
  endtask

  task automatic pulse(input string req);
    drive_step(1'b1, cur_code, cur_div, cur_pie, req);
    drive_step(1'b0, cur_code, cur_div, cur_pie, req);
  endtask

  task automatic set_ctl(input logic [3:0] c, input logic [2:0] d, input logic ie, input string req);
    cur_code = c; cur_div = d; cur_pie = ie;
    drive_step(1'b0, c, d, ie, req);
  endtask

  task automatic clear_counter(input string req);
    set_ctl(cur_code, 3'b110, cur_pie, req);
    set_ctl(cur_code, 3'b010, cur_pie, req);
  endtask

  task automatic t_reset;  // R1
    rst_n = 1'b0; tb_en = 1'b0; rate_code = 4'd0; div_ctl = 3'd0; pie = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 during reset", {tick, pf_set, irq_set}, 3'b000);
    rst_n = 1'b1;
    repeat (4) drive_step(1'b0, 4'd0, 3'd0, 1'b0, "R1 after release");
  endtask

  task automatic t_code_zero;  // R2
    set_ctl(4'd0, 3'd2, 1'b1, "R2");
    n_ticks = 0;
    repeat (300) pulse("R2 code 0 no tick");
    check_int("R2 tick count with code 0", n_ticks, 0);
  endtask

  task automatic t_basic;  // R3 R5 R6 with pie set
    set_ctl(4'd3, 3'd0, 1'b1, "R3");
    clear_counter("R3");
    set_ctl(4'd3, 3'd0, 1'b1, "R3");
    n_ticks = 0;
    repeat (64) pulse("R3 R6 period 4 with pie");
    check_int("R3 ticks in 64 pulses at code 3", n_ticks, 16);
    set_ctl(4'd5, 3'd1, 1'b0, "R6");
    n_ticks = 0;
    repeat (64) pulse("R6 period 16 without pie");
    check_int("R3 ticks in 64 pulses at code 5", n_ticks, 4);
  endtask

  task automatic t_remap;  // R4
    set_ctl(4'd1, 3'd2, 1'b1, "R4");
    clear_counter("R4");
    n_ticks = 0;
    repeat (300) pulse("R4 code 1");
    check_int("R4 code 1 ticks in 300 pulses", n_ticks, 2);
    set_ctl(4'd2, 3'd2, 1'b1, "R4");
    clear_counter("R4");
    n_ticks = 0;
    repeat (600) pulse("R4 code 2");
    check_int("R4 code 2 ticks in 600 pulses", n_ticks, 2);
  endtask

  task automatic t_wrap;  // R3 R5 at code 15
    set_ctl(4'd15, 3'd2, 1'b1, "R5");
    clear_counter("R5");
    n_ticks = 0;
    repeat (32768) pulse("R5 code 15 with wrap");
    check_int("R5 code 15 ticks over full counter", n_ticks, 2);
  endtask

  task automatic t_hold;  // R7
    set_ctl(4'd3, 3'd2, 1'b1, "R7");
    clear_counter("R7");
    repeat (3) pulse("R7 run");
    set_ctl(4'd3, 3'b011, 1'b1, "R7");
    n_ticks = 0;
    repeat (10) pulse("R7 frozen by 3");
    set_ctl(4'd3, 3'b101, 1'b1, "R7");
    repeat (10) pulse("R7 frozen by 5");
    check_int("R7 ticks while frozen", n_ticks, 0);
    set_ctl(4'd3, 3'b000, 1'b1, "R7");
    pulse("R7 resume ticks at count 4");
    check_int("R7 tick right after resume", n_ticks, 1);
  endtask

  task automatic t_div_reset;  // R8
    set_ctl(4'd4, 3'd2, 1'b1, "R8");
    repeat (5) pulse("R8 run");
    set_ctl(4'd4, 3'b111, 1'b1, "R8");
    n_ticks = 0;
    repeat (20) pulse("R8 held in reset");
    check_int("R8 ticks during divider reset", n_ticks, 0);
    set_ctl(4'd4, 3'd2, 1'b1, "R8");
    repeat (7) pulse("R8 first period");
    check_int("R8 no tick before full period", n_ticks, 0);
    pulse("R8 tick at full period");
    check_int("R8 tick after 8 pulses", n_ticks, 1);
  endtask

  task automatic t_code_change;  // R9
    set_ctl(4'd4, 3'd2, 1'b1, "R9");
    clear_counter("R9");
    repeat (7) pulse("R9 run at period 8");
    n_ticks = 0;
    cur_code = 4'd3;
    drive_step(1'b1, 4'd3, 3'd2, 1'b1, "R9 change lands on boundary");
    drive_step(1'b0, 4'd3, 3'd2, 1'b1, "R9");
    check_int("R9 no tick on code change", n_ticks, 0);
    repeat (8) pulse("R9 after change");
    check_int("R9 ticks after change", n_ticks, 2);
  endtask

  task automatic t_continuous;  // R10
    set_ctl(4'd3, 3'd2, 1'b0, "R10");
    clear_counter("R10");
    n_ticks = 0;
    repeat (40) drive_step(1'b1, 4'd3, 3'd2, 1'b0, "R10 enable held high");
    drive_step(1'b0, 4'd3, 3'd2, 1'b0, "R10");
    check_int("R10 ticks in 40 consecutive pulses", n_ticks, 10);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_code_zero();
    t_basic();
    t_remap();
    t_hold();
    t_div_reset();
    t_code_change();
    t_continuous();
    t_wrap();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule